// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM with a 20-bit address, a 4-bit bidirectional data bus and active-low select, output-enable and write-enable strobes. The host offers one word at a time through a valid/ready handshake. Each request carries an address, write data and a write flag. Read data comes back on a response bus that is qualified by a single-cycle valid strobe. Writes produce no response.

On the memory side the controller drives the address, the three strobes, the outgoing data and a drive-enable for the data pads. It also receives the incoming data. Every strobe is a flop output, so the memory pins never glitch. Each phase of an access lasts a parameter number of clock cycles. These lengths can be raised for faster clocks while still meeting the memory's minimum read cycle, write pulse, data setup and bus release times.

States: `ST_IDLE` (memory in standby, ready high), `ST_RD_ACCESS` (select and output-enable low), `ST_WR_TURN` (bus release after a read), `ST_WR_SETUP` (address and data driven, write-enable high), `ST_WR_PULSE` (write-enable low), `ST_WR_HOLD` (write-enable high, address and data still held). Transitions:
- `ST_IDLE` goes to `ST_RD_ACCESS` when a read is accepted.
- `ST_IDLE` goes to `ST_WR_TURN` when a write is accepted and the last access was a read. It goes to `ST_WR_SETUP` when a write is accepted otherwise.
- `ST_WR_TURN` goes to `ST_WR_SETUP`, `ST_WR_SETUP` goes to `ST_WR_PULSE`, and `ST_WR_PULSE` goes to `ST_WR_HOLD`, each when its phase timer expires.
- `ST_RD_ACCESS` and `ST_WR_HOLD` return to `ST_IDLE` when their phase timers expire.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset and whenever idle, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dout_en` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 with the address stable for READ_CYC cycles. The data present at the last of those edges appears on `rsp_rdata`, and `rsp_valid` is high for exactly one cycle.
- R3: A write drives address and data with `mem_cs_n`=0 and `mem_we_n`=1 for SETUP_CYC cycles, then holds `mem_we_n`=0 for exactly PULSE_CYC cycles.
- R4: `mem_oe_n` stays 1 for the whole write, and `mem_dout_en` is never 1 while `mem_oe_n` is 0.
- R5: `req_ready` is 0 from the cycle after a request is accepted until the controller is idle again. Requests are taken only when `req_ready` is 1.
- R6: When a write follows a read, `mem_dout_en` stays 0 with `mem_cs_n`=1 for TURN_CYC cycles first. A write that follows a write skips this phase.
- R7: After `mem_we_n` rises, `mem_cs_n`=0, the address and the data stay driven for HOLD_CYC cycles. Only then do `mem_dout_en` go to 0 and `mem_cs_n` go to 1.
- R8: `mem_addr` changes only while `mem_cs_n` is 1.
- R9: A write produces no `rsp_valid` pulse. The number of responses equals the number of reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | 4 | Read data |
| mem_addr | output | 20 | Memory address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dout | output | 4 | Data toward the memory |
| mem_din | input | 4 | Data from the memory |
| mem_dout_en | output | 1 | Pad drive enable for mem_dout |

## Verification
The assertions assume that the host keeps a request stable until the cycle in which `req_ready` is sampled high. They also assume that every phase parameter is at least 1. The bench's driver changes request fields only at falling edges, after it has seen `req_ready` high, and drops `req_valid` one cycle later. The memory model answers only while select and output-enable are low and write-enable is high. It stores a word only when select, write-enable and the drive-enable coincide, so a pin sequence outside these rules shows up as wrong read data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_WR_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctrl_state_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_STANDBY = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    function automatic pin_ctl_t pins_for(input ctrl_state_e st);
        pin_ctl_t p;
        p = PINS_STANDBY;
        unique case (st)
            ST_IDLE:      p = PINS_STANDBY;
            ST_WR_TURN:   p = PINS_STANDBY;
            ST_RD_ACCESS: begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
            ST_WR_SETUP:  begin p.cs_n = 1'b0; p.drive = 1'b1; end
            ST_WR_PULSE:  begin p.cs_n = 1'b0; p.we_n = 1'b0; p.drive = 1'b1; end
            ST_WR_HOLD:   begin p.cs_n = 1'b0; p.drive = 1'b1; end
            default:      p = PINS_STANDBY;
        endcase
        return p;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_wdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_addr  <= '0;
            hold_wdata <= '0;
        end else if (take) begin
            hold_addr  <= in_addr;
            hold_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            valid <= 1'b0;
        end else begin
            valid <= sample;
            if (sample) begin
                rdata <= din;
            end
        end
    end

    AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R2
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 4,
    parameter int READ_CYC  = 1,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 1,
    parameter int HOLD_CYC  = 1,
    parameter int TURN_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_dout_en
);
    localparam int LONGEST = max_of(max_of(READ_CYC, SETUP_CYC),
                                    max_of(max_of(PULSE_CYC, HOLD_CYC), TURN_CYC));
    localparam int CNT_W   = $clog2(LONGEST + 1);

    ctrl_state_e      state_q, state_nx;
    logic             accept;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             last_rd_q;
    pin_ctl_t         pins_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // next-state selection
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write)     state_nx = ST_RD_ACCESS;
                    else if (last_rd_q) state_nx = ST_WR_TURN;
                    else                state_nx = ST_WR_SETUP;
                end
            end
            ST_RD_ACCESS: if (tmr_done) state_nx = ST_IDLE;
            ST_WR_TURN:   if (tmr_done) state_nx = ST_WR_SETUP;
            ST_WR_SETUP:  if (tmr_done) state_nx = ST_WR_PULSE;
            ST_WR_PULSE:  if (tmr_done) state_nx = ST_WR_HOLD;
            ST_WR_HOLD:   if (tmr_done) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // phase length for the state being entered
    always_comb begin
        tmr_val = '0;
        unique case (state_nx)
            ST_RD_ACCESS: tmr_val = CNT_W'(READ_CYC - 1);
            ST_WR_TURN:   tmr_val = CNT_W'(TURN_CYC - 1);
            ST_WR_SETUP:  tmr_val = CNT_W'(SETUP_CYC - 1);
            ST_WR_PULSE:  tmr_val = CNT_W'(PULSE_CYC - 1);
            ST_WR_HOLD:   tmr_val = CNT_W'(HOLD_CYC - 1);
            default:      tmr_val = '0;
        endcase
    end
    assign tmr_load = (state_nx != state_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            last_rd_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_RD_ACCESS)     last_rd_q <= 1'b1;
            else if (state_q == ST_WR_SETUP) last_rd_q <= 1'b0;
        end
    end

    // registered pin strobes, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= PINS_STANDBY;
        else        pins_q <= pins_for(state_nx);
    end

    assign mem_cs_n    = pins_q.cs_n;
    assign mem_oe_n    = pins_q.oe_n;
    assign mem_we_n    = pins_q.we_n;
    assign mem_dout_en = pins_q.drive;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (accept),
        .in_addr    (req_addr),
        .in_wdata   (req_wdata),
        .hold_addr  (mem_addr),
        .hold_wdata (mem_dout)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (state_q == ST_RD_ACCESS && tmr_done),
        .din    (mem_din),
        .rdata  (rsp_rdata),
        .valid  (rsp_valid)
    );

    // checker support: widths of write pulse and of output-enable high time
    logic [CNT_W:0]   we_low_cnt;
    logic [CNT_W+1:0] oe_hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_hi_cnt  <= '1;
        end else begin
            we_low_cnt <= mem_we_n ? '0 : we_low_cnt + 1'b1;
            if (!mem_oe_n)           oe_hi_cnt <= '0;
            else if (oe_hi_cnt != '1) oe_hi_cnt <= oe_hi_cnt + 1'b1;
        end
    end

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en); // R1
    AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> we_low_cnt == (CNT_W+1)'(PULSE_CYC)); // R3
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dout_en && !mem_oe_n)); // R4
    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n && !mem_cs_n && mem_dout_en); // R4
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready); // R5
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dout_en) |-> oe_hi_cnt > (CNT_W+2)'(TURN_CYC)); // R6
    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dout_en && !mem_cs_n); // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R8
    AST_NO_WRITE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || mem_dout_en) |-> !rsp_valid); // R9
endmodule

// File: tb/sram_bus_ctrl_test.sv
module sram_bus_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 4;
    localparam int P_READ  = 1;
    localparam int P_SETUP = 1;
    localparam int P_PULSE = 1;
    localparam int P_HOLD  = 1;
    localparam int P_TURN  = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [DW-1:0] mem_dout;
    logic [DW-1:0] mem_din = '0;

    int checks = 0;
    int errors = 0;
    int reads_issued = 0;
    int rsp_seen = 0;
    bit last_rd = 1'b0;
    bit prev_valid = 1'b0;

    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] ref_mem[logic [AW-1:0]];
    logic [DW-1:0] pin_mem[logic [AW-1:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bus_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .READ_CYC(P_READ), .SETUP_CYC(P_SETUP),
        .PULSE_CYC(P_PULSE), .HOLD_CYC(P_HOLD), .TURN_CYC(P_TURN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_dout_en(mem_dout_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // memory model: stores on select+write+drive overlap, answers reads
    always @(negedge clk) begin
        if (rst_n && !mem_cs_n && !mem_we_n && mem_dout_en)
            pin_mem[mem_addr] = mem_dout;
        if (!mem_cs_n && !mem_oe_n && mem_we_n)
            mem_din = pin_mem.exists(mem_addr) ? pin_mem[mem_addr] : '0;
        else
            mem_din = '0;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                rsp_seen++;
                chk(!prev_valid, "R2 single pulse", {31'd0, prev_valid}, 32'd0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected response", {28'd0, rsp_rdata}, 32'd0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata == e, "R2 read data", {28'd0, rsp_rdata}, {28'd0, e});
                end
            end
            prev_valid = rsp_valid;
        end
    end

    task automatic do_access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R5 ready low while busy", {31'd0, req_ready}, 32'd0);
        if (wr) begin
            ref_mem[a] = d;
            if (last_rd) begin
                for (int k = 0; k < P_TURN; k++) begin
                    chk(!mem_dout_en && mem_cs_n, "R6 turnaround no drive",
                        {30'd0, mem_dout_en, mem_cs_n}, 32'd1);
                    @(negedge clk);
                end
            end
            for (int k = 0; k < P_SETUP; k++) begin
                chk(!mem_cs_n && mem_we_n && mem_dout_en && mem_dout == d && mem_addr == a,
                    "R3 setup phase", {27'd0, mem_dout, mem_we_n}, {27'd0, d, 1'b1});
                chk(!(wr && last_rd && k == 0 && P_TURN == 0), "R6 order", 32'd0, 32'd0);
                @(negedge clk);
            end
            for (int k = 0; k < P_PULSE; k++) begin
                chk(!mem_we_n && !mem_cs_n, "R3 write pulse low", {31'd0, mem_we_n}, 32'd0);
                chk(mem_oe_n, "R4 oe high during write", {31'd0, mem_oe_n}, 32'd1);
                @(negedge clk);
            end
            for (int k = 0; k < P_HOLD; k++) begin
                chk(mem_we_n && !mem_cs_n && mem_dout_en && mem_addr == a && mem_dout == d,
                    "R7 hold after write", {30'd0, mem_dout_en, mem_cs_n}, 32'd2);
                chk(mem_oe_n, "R4 oe high in hold", {31'd0, mem_oe_n}, 32'd1);
                @(negedge clk);
            end
            chk(!mem_dout_en && mem_cs_n && req_ready, "R7 release then idle",
                {29'd0, mem_dout_en, mem_cs_n, req_ready}, 32'd3);
            chk(!rsp_valid, "R9 no response for write", {31'd0, rsp_valid}, 32'd0);
            last_rd = 1'b0;
        end else begin
            exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : '0);
            reads_issued++;
            chk(!mem_cs_n && !mem_oe_n && mem_we_n && !mem_dout_en && mem_addr == a,
                "R2 read strobes", {28'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en}, 32'd2);
            last_rd = 1'b1;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en && !rsp_valid,
            "R1 reset pins", {28'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en}, 32'he);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_cs_n && !mem_dout_en, "R1 idle after reset",
            {29'd0, req_ready, mem_cs_n, mem_dout_en}, 32'd6);

        do_access(1'b1, 20'h00000, 4'hA);
        do_access(1'b1, 20'hFFFFF, 4'h5);   // write after write: no turnaround (R6)
        do_access(1'b0, 20'h00000, 4'h0);
        do_access(1'b0, 20'hFFFFF, 4'h0);
        do_access(1'b1, 20'h12345, 4'hF);   // write after read: turnaround (R6)
        do_access(1'b0, 20'h12345, 4'h0);
        do_access(1'b0, 20'h00777, 4'h0);   // never written
        do_access(1'b1, 20'h12345, 4'h0);   // overwrite
        do_access(1'b0, 20'h12345, 4'h0);
        for (int i = 0; i < 8; i++) begin
            do_access(1'b1, AW'(i * 20'h11111), DW'(i ^ 5));
            if (i % 2 == 1) do_access(1'b0, AW'((i - 1) * 20'h11111), 4'h0);
        end
        for (int i = 0; i < 8; i++) do_access(1'b0, AW'(i * 20'h11111), 4'h0);

        repeat (5) @(negedge clk);
        chk(rsp_seen == reads_issued, "R9 response count", rsp_seen, reads_issued);
        chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 32'd0);
        chk(req_ready && mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en,
            "R1 idle at end", {31'd0, req_ready}, 32'd1);
        summary();
    end
endmodule